// File: doc/BRIEF.md
# Voltage Identifier Transition Engine

This block moves a 7-bit voltage identifier (VID) driven to a supply regulator from its present code to a requested one. A caller pulses a request together with a target code, a mode bit and two 3-bit time selects. In slam mode the engine presents the target in one update and then waits a settling time. In step mode it walks the code one unit (12.5 mV) per update toward the target and waits a settling time after every single unit, including the last.

Settling time is counted in whole ticks of a one-microsecond enable input, so the wait scales with that input and not with the clock. A transition that has begun always finishes: further requests are dropped until the engine reports completion with a single-cycle done pulse. A request whose target already equals the present code completes at once, with no update and no wait.

Top module: `vid_ramp_engine`

## Requirements
- R1: In reset and in the cycle after it, `vid_out` equals the parameter `RESET_VID` (default 7'h40), and `vid_upd`, `busy` and `done` are 0.
- R2: With `req_slam`=1 at acceptance, the cycle after the accepting edge shows `vid_out` equal to the target with `vid_upd`=1, and the transition has exactly one `vid_upd` pulse.
- R3: With `req_slam`=0, each `vid_upd` pulse comes in the same cycle as a change of `vid_out` by exactly one code, updates continue until `vid_out` equals the target, and `vid_out` never changes without `vid_upd`.
- R4: A time select of 000,001,010,011,100,101,110,111 gives a wait of 10,20,30,40,60,100,200,500 ticks.
- R5: Slam mode waits the time given by `slam_time_sel`; step mode waits the time given by `ramp_time_sel` after every step, including the final one.
- R6: A wait counts only cycles with `us_tick`=1. Ticks sampled at the same edge as an update are not counted. The next update, or `done`, appears in the cycle after the edge that samples the Nth tick.
- R7: `done` is a one-cycle pulse in the cycle after the final wait expires. `busy` is 1 from the cycle after acceptance until that wait expires, and it is 0 while `done` is 1.
- R8: A request is accepted only while `busy`=0. The target, mode and both time selects are captured at acceptance, and requests seen while busy have no effect.
- R9: A request whose target equals `vid_out` gives `done`=1 in the next cycle, no `vid_upd` and no `busy`.
- R10: In step mode the direction of each step comes from comparing the target with `vid_out`, so codes are walked both upward and downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transition request strobe |
| req_vid | input | VID_W | Target code |
| req_slam | input | 1 | 1 = slam mode, 0 = step mode |
| slam_time_sel | input | 3 | Settling time select for slam mode |
| ramp_time_sel | input | 3 | Settling time select per step |
| us_tick | input | 1 | One-microsecond enable |
| vid_out | output | VID_W | Code driven to the regulator |
| vid_upd | output | 1 | Pulse marking a new code on vid_out |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default parameters: a 7-bit code and a reset code of 7'h40 at mid-scale. This lets it step both up and down and also slam to the far ends of the range. It drives the tick on every cycle for most runs, which keeps even the 500-tick select within a few hundred cycles. For one run it drives the tick only every third cycle, which makes gaps between ticks visible in the wait. A behavioural model follows every cycle, and directed runs sweep all eight time selects. They also cover equal targets and requests issued during a transition.

// File: rtl/vid_pkg.sv
package vid_pkg;

    localparam int SEL_W = 3;
    localparam int DLY_W = 9;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic             slam;
        logic [SEL_W-1:0] slam_sel;
        logic [SEL_W-1:0] ramp_sel;
    } xfer_cfg_t;

    function automatic logic [DLY_W-1:0] settle_ticks(input logic [SEL_W-1:0] sel);
        logic [DLY_W-1:0] t;
        case (sel)
            3'd0:    t = DLY_W'(10);
            3'd1:    t = DLY_W'(20);
            3'd2:    t = DLY_W'(30);
            3'd3:    t = DLY_W'(40);
            3'd4:    t = DLY_W'(60);
            3'd5:    t = DLY_W'(100);
            3'd6:    t = DLY_W'(200);
            default: t = DLY_W'(500);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/vid_settle_timer.sv
module vid_settle_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - LAST;
        end
    end

    assign expire = tick && (cnt_q == LAST);

endmodule

// File: rtl/vid_next_code.sv
module vid_next_code #(
    parameter int VID_W = 7
) (
    input  logic [VID_W-1:0] cur,
    input  logic [VID_W-1:0] tgt,
    input  logic             slam,
    output logic [VID_W-1:0] nxt,
    output logic             at_tgt
);
    localparam logic [VID_W-1:0] UNIT = VID_W'(1);

    always_comb begin
        at_tgt = (cur == tgt);
        if (slam || at_tgt) begin
            nxt = tgt;
        end else if (tgt > cur) begin
            nxt = cur + UNIT;
        end else begin
            nxt = cur - UNIT;
        end
    end

endmodule

// File: rtl/vid_ramp_engine.sv
module vid_ramp_engine
    import vid_pkg::*;
#(
    parameter int               VID_W     = 7,
    parameter logic [VID_W-1:0] RESET_VID = 7'h40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [VID_W-1:0]     req_vid,
    input  logic                 req_slam,
    input  logic [SEL_W-1:0]     slam_time_sel,
    input  logic [SEL_W-1:0]     ramp_time_sel,
    input  logic                 us_tick,
    output logic [VID_W-1:0]     vid_out,
    output logic                 vid_upd,
    output logic                 busy,
    output logic                 done
);
    eng_state_e       state_q;
    xfer_cfg_t        cfg_q;
    xfer_cfg_t        cfg_use;
    logic [VID_W-1:0] tgt_q;
    logic [VID_W-1:0] tgt_use;
    logic [VID_W-1:0] vid_q;
    logic [VID_W-1:0] vid_nxt;
    logic             at_tgt;
    logic             accept;
    logic             start;
    logic             step_issue;
    logic             finish;
    logic             issue;
    logic             expire;
    logic             upd_q;
    logic             done_q;
    logic [DLY_W-1:0] wait_len;

    assign accept  = (state_q == ST_IDLE) && req;
    assign cfg_use = accept ? xfer_cfg_t'{slam: req_slam, slam_sel: slam_time_sel,
                                          ramp_sel: ramp_time_sel} : cfg_q;
    assign tgt_use = accept ? req_vid : tgt_q;

    vid_next_code #(.VID_W(VID_W)) u_next (
        .cur    (vid_q),
        .tgt    (tgt_use),
        .slam   (cfg_use.slam),
        .nxt    (vid_nxt),
        .at_tgt (at_tgt)
    );

    assign start      = accept && !at_tgt;
    assign step_issue = (state_q == ST_WAIT) && expire && !at_tgt;
    assign finish     = (state_q == ST_WAIT) && expire && at_tgt;
    assign issue      = start || step_issue;
    assign wait_len   = settle_ticks(cfg_use.slam ? cfg_use.slam_sel : cfg_use.ramp_sel);

    vid_settle_timer #(.CNT_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (issue),
        .load_val (wait_len),
        .tick     (us_tick),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            tgt_q   <= RESET_VID;
            vid_q   <= RESET_VID;
            upd_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            upd_q  <= issue;
            done_q <= (accept && at_tgt) || finish;
            if (accept) begin
                cfg_q <= cfg_use;
                tgt_q <= req_vid;
            end
            if (issue) begin
                vid_q <= vid_nxt;
            end
            if (start) begin
                state_q <= ST_WAIT;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign vid_out = vid_q;
    assign vid_upd = upd_q;
    assign busy    = (state_q == ST_WAIT);
    assign done    = done_q;

endmodule

// File: rtl/vid_ramp_engine_chk.sv
module vid_ramp_engine_chk #(
    parameter int VID_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             req,
    input logic             busy,
    input logic             done,
    input logic             vid_upd,
    input logic [VID_W-1:0] vid_out,
    input logic [VID_W-1:0] tgt_q,
    input logic             slam_q
);
    localparam logic [VID_W-1:0] ONE = VID_W'(1);

    AST_SLAM_HITS_TARGET: assert property (@(posedge clk) disable iff (rst)
        vid_upd && slam_q |-> vid_out == tgt_q); // R2

    AST_STEP_ONE_CODE: assert property (@(posedge clk) disable iff (rst)
        vid_upd && !slam_q |-> (vid_out == $past(vid_out) + ONE) ||
                               (vid_out == $past(vid_out) - ONE)); // R3

    AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !vid_upd |-> $stable(vid_out)); // R3

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_BUSY_HOLDS_TARGET: assert property (@(posedge clk) disable iff (rst)
        busy && req |=> $stable(tgt_q)); // R8

endmodule

bind vid_ramp_engine vid_ramp_engine_chk #(.VID_W(VID_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .vid_upd (vid_upd),
    .vid_out (vid_out),
    .tgt_q   (tgt_q),
    .slam_q  (cfg_q.slam)
);

// File: tb/sim_vid_ramp_engine.sv
module sim_vid_ramp_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [6:0] req_vid = 7'h00;
    logic       req_slam = 1'b0;
    logic [2:0] slam_time_sel = 3'd0;
    logic [2:0] ramp_time_sel = 3'd0;
    logic       us_tick = 1'b0;
    logic [6:0] vid_out;
    logic       vid_upd;
    logic       busy;
    logic       done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 1;

    always #2.5 clk = ~clk;

    vid_ramp_engine u0 (
        .clk(clk), .rst(rst), .req(req), .req_vid(req_vid), .req_slam(req_slam),
        .slam_time_sel(slam_time_sel), .ramp_time_sel(ramp_time_sel),
        .us_tick(us_tick), .vid_out(vid_out), .vid_upd(vid_upd),
        .busy(busy), .done(done)
    );

    function automatic int tbl(input logic [2:0] s);
        int v[8] = '{10, 20, 30, 40, 60, 100, 200, 500};
        return v[s];
    endfunction

    // behavioural reference, advanced once per rising edge
    int   m_vid = 'h40;
    int   m_tgt = 'h40;
    int   m_wait = 0;
    bit   m_busy = 0, m_done = 0, m_upd = 0, m_slam = 0;
    int   m_ssel = 0, m_rsel = 0;

    task automatic m_issue();
        if (m_slam) m_vid = m_tgt;
        else if (m_tgt > m_vid) m_vid = m_vid + 1;
        else m_vid = m_vid - 1;
        m_upd  = 1;
        m_busy = 1;
        m_wait = tbl(m_slam ? m_ssel[2:0] : m_rsel[2:0]);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        m_done = 0;
        m_upd  = 0;
        if (rst) begin
            m_vid = 'h40; m_tgt = 'h40; m_busy = 0; m_wait = 0;
        end else if (!m_busy) begin
            if (req) begin
                m_tgt = req_vid; m_slam = req_slam;
                m_ssel = slam_time_sel; m_rsel = ramp_time_sel;
                if (m_tgt == m_vid) m_done = 1;
                else m_issue();
            end
        end else if (us_tick) begin
            m_wait = m_wait - 1;
            if (m_wait == 0) begin
                if (m_vid == m_tgt) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_issue();
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(vid_out) == m_vid, "R3 R10 vid_out", vid_out, m_vid);
            chk(vid_upd == m_upd, "R2 R3 vid_upd", vid_upd, m_upd);
            chk(busy == m_busy, "R6 R7 busy", busy, m_busy);
            chk(done == m_done, "R6 R7 R9 done", done, m_done);
        end
    end

    // tick source
    initial begin
        forever begin
            @(negedge clk);
            us_tick = (cyc % tick_div) == 0;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic fire(input int tgt, input bit slam, input int ss, input int rs);
        @(negedge clk);
        req = 1'b1; req_vid = tgt[6:0]; req_slam = slam;
        slam_time_sel = ss[2:0]; ramp_time_sel = rs[2:0];
        @(negedge clk);
        req = 1'b0;
    endtask

    // waits for done; reports update count and cycles from first update to done
    task automatic wait_done(output int n_upd, output int span, output bit saw_busy);
        int first = -1;
        n_upd = 0; span = 0; saw_busy = 0;
        for (int i = 0; i < 60000; i++) begin
            if (vid_upd) begin
                n_upd++;
                if (first < 0) first = cyc;
            end
            if (busy) saw_busy = 1;
            if (done) begin
                span = (first < 0) ? 0 : cyc - first;
                return;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int nu, sp;
        bit sb;
        repeat (3) @(negedge clk);
        chk(vid_out == 7'h40 && !vid_upd && !busy && !done, "R1 reset state", vid_out, 'h40);
        rst = 1'b0;
        @(negedge clk);
        chk(vid_out == 7'h40 && !vid_upd && !busy && !done, "R1 after reset", vid_out, 'h40);

        // slam up, then all eight slam selects alternating targets
        fire('h50, 1'b1, 0, 7);
        chk(vid_upd && vid_out == 7'h50, "R2 slam lands next cycle", vid_out, 'h50);
        wait_done(nu, sp, sb);
        chk(nu == 1, "R2 single update", nu, 1);
        chk(sp == 10, "R4 R5 slam uses slam select 000", sp, 10);
        for (int s = 0; s < 8; s++) begin
            fire((s % 2) ? 'h50 : 'h48, 1'b1, s, 0);
            wait_done(nu, sp, sb);
            chk(nu == 1 && sp == tbl(s[2:0]), "R4 slam select wait", sp, tbl(s[2:0]));
        end

        // step up 0x50 -> 0x53, ramp select 001
        fire('h53, 1'b0, 7, 1);
        wait_done(nu, sp, sb);
        chk(nu == 3, "R3 step update count", nu, 3);
        chk(sp == 2 * 20 + 20, "R5 wait after every step", sp, 60);
        chk(vid_out == 7'h53, "R3 reaches target", vid_out, 'h53);

        // step down with sparse ticks
        tick_div = 3;
        fire('h50, 1'b0, 0, 0);
        wait_done(nu, sp, sb);
        chk(nu == 3 && vid_out == 7'h50, "R10 step down", vid_out, 'h50);
        chk(sp >= 3 * 10 * 3 - 3 && sp <= 3 * 10 * 3 + 3, "R6 only ticks count", sp, 90);
        tick_div = 1;

        // equal target
        fire('h50, 1'b0, 7, 7);
        chk(done && !vid_upd && !busy, "R9 equal target done", done, 1);
        @(negedge clk);
        chk(!done && vid_out == 7'h50, "R9 no change", vid_out, 'h50);

        // requests during a transition are dropped
        fire('h10, 1'b1, 7, 0);
        repeat (20) @(negedge clk);
        fire('h7F, 1'b0, 0, 0);
        wait_done(nu, sp, sb);
        chk(vid_out == 7'h10 && nu == 0, "R8 mid request ignored", vid_out, 'h10);
        repeat (3) @(negedge clk);
        chk(vid_out == 7'h10 && !busy, "R8 still idle at first target", vid_out, 'h10);

        // long per-step wait, two steps down
        fire('h0E, 1'b0, 0, 7);
        wait_done(nu, sp, sb);
        chk(nu == 2 && sp == 1000, "R4 R5 ramp select 111 per step", sp, 1000);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule